// File: doc/BRIEF.md
# Event-Selectable Cache Performance Counters

This block holds four counters that measure the activity of a cache controller. Each counter has its own event selector. The selector picks one line of a vector of single-cycle event pulses, or a free-running cycle event. The cache logic drives the pulses on `evt_i` and this block only counts them. A configuration write chooses a counter, an event code and a clear-on-read flag. A read strobe returns a counter's full value on the next cycle.

Each counter has its own clear-on-read option. When the option is set, a read also zeroes the counter, so software gets a count for each interval without a separate clear step. Reprogramming a counter changes what it counts from then on, but it never touches the value already accumulated.

Top module: `cache_perf_counters`

## Requirements
- R1: After reset every counter is 0, `rd_valid_o` and `rd_data_o` are 0, every selector holds the idle code 54, and clear-on-read is off.
- R2: A read strobe with index `rd_idx_i` (0 to 3) sets `rd_valid_o` on the next cycle. In that cycle `rd_data_o` carries the full-width value the counter had in the strobe cycle. Without a strobe, `rd_valid_o` is 0 on the next cycle.
- R3: With event code 0, a counter increments on every clock cycle.
- R4: With event code k from 1 to 53, a counter increments in exactly the cycles where `evt_i[k]` is 1. `evt_i[0]` has no effect.
- R5: With an event code of 54 to 63, a counter holds its value.
- R6: A read of a counter with clear-on-read set returns the old value. The counter then holds 1 if its selected event fired in the read cycle, and 0 if it did not.
- R7: A read of a counter with clear-on-read off leaves the count unchanged.
- R8: A configuration write (`cfg_idx_i`, `cfg_evt_i`, `cfg_cor_i`) keeps the count. The new event and flag apply from the next cycle on.
- R9: A counter at its maximum wraps to 0 on its next increment, with no other effect.
- R10: Each counter follows only its own configuration and reads. A write or a read addressed to one counter does not affect the other counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 54 | Event pulses; bit k belongs to event code k |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Counter addressed by the write |
| cfg_evt_i | input | 6 | Event code to install |
| cfg_cor_i | input | 1 | Clear-on-read flag to install |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 2 | Counter addressed by the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | 64 | Counter value captured at the strobe |

## Verification
Several properties are checked on every clock cycle:
- the read port returns the count from the strobe cycle, one cycle later;
- a cycle-counting counter steps by exactly one;
- an idle selector freezes its counter;
- a clear-on-read access leaves at most 1 behind.

Some behaviour shows only in the bench's scenarios, where a behavioural model tracks all four counters under random event traffic:
- which pulse line each code picks;
- a reprogrammed counter keeping its value;
- reads without the flag leaving the count alone;
- wraparound, shown on a second, 8-bit instance.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int NUM_EVENTS  = 54;
  localparam int EVT_CODE_W  = 6;
  localparam int CODE_CYCLES = 0;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
  parameter int NUM_EVT = 54,
  parameter int EVT_W   = 6
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [EVT_W-1:0]   code_i,
  output logic               hit_o
);
  logic in_range;
  assign in_range = int'(code_i) < NUM_EVT;

  // code 0 counts cycles; out-of-range codes are idle
  always_comb begin
    hit_o = (code_i == '0);
    if (in_range) hit_o = hit_o | evt_i[code_i];
  end
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice #(
  parameter int NUM_EVT = 54,
  parameter int EVT_W   = 6,
  parameter int CNT_W   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg_we_i,
  input  logic [EVT_W-1:0]   cfg_evt_i,
  input  logic               cfg_cor_i,
  input  logic               rd_sel_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [EVT_W-1:0]   code_o,
  output logic               cor_o
);
  localparam logic [EVT_W-1:0] IDLE_CODE = EVT_W'(NUM_EVT);

  logic [EVT_W-1:0] code_q;
  logic             cor_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= IDLE_CODE;
      cor_q  <= 1'b0;
    end else if (cfg_we_i) begin
      code_q <= cfg_evt_i;
      cor_q  <= cfg_cor_i;
    end
  end

  perf_evt_sel #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_sel (
    .evt_i  (evt_i),
    .code_i (code_q),
    .hit_o  (hit)
  );

  // a clearing read restarts at the current cycle's event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (rd_sel_i && cor_q) cnt_q <= CNT_W'(hit);
    else if (hit)               cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign code_o = code_q;
  assign cor_o  = cor_q;
endmodule

// File: rtl/perf_rd_port.sv
module perf_rd_port #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 64,
  parameter int IDX_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all_i,
  output logic                          rd_valid_o,
  output logic [CNT_W-1:0]              rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= cnt_all_i[rd_idx_i];
    end
  end
endmodule

// File: rtl/cache_perf_counters.sv
module cache_perf_counters
  import perf_pkg::*;
#(
  parameter  int NUM_CNT = 4,
  parameter  int CNT_W   = 64,
  parameter  int NUM_EVT = NUM_EVENTS,
  parameter  int EVT_W   = EVT_CODE_W,
  localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [EVT_W-1:0]   cfg_evt_i,
  input  logic               cfg_cor_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [CNT_W-1:0]   rd_data_o
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0][EVT_W-1:0] code_all;
  logic [NUM_CNT-1:0]            cor_all;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slice
    logic we_hit, rd_hit;
    assign we_hit = cfg_we_i && (cfg_idx_i == IDX_W'(i));
    assign rd_hit = rd_en_i  && (rd_idx_i  == IDX_W'(i));

    perf_cnt_slice #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .cfg_we_i  (we_hit),
      .cfg_evt_i (cfg_evt_i),
      .cfg_cor_i (cfg_cor_i),
      .rd_sel_i  (rd_hit),
      .cnt_o     (cnt_all[i]),
      .code_o    (code_all[i]),
      .cor_o     (cor_all[i])
    );
  end

  perf_rd_port #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .cnt_all_i  (cnt_all),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/cache_perf_counters_chk.sv
module cache_perf_counters_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 64,
  parameter int NUM_EVT = 54,
  parameter int EVT_W   = 6,
  parameter int IDX_W   = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rd_en_i,
  input logic [IDX_W-1:0]              rd_idx_i,
  input logic                          rd_valid_o,
  input logic [CNT_W-1:0]              rd_data_o,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CNT-1:0][EVT_W-1:0] code_all,
  input logic [NUM_CNT-1:0]            cor_all
);
  p_rd_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_valid_o && rd_data_o == $past(cnt_all[rd_idx_i])));

  p_rd_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    logic clr;
    assign clr = rd_en_i && (rd_idx_i == IDX_W'(i)) && cor_all[i];

    p_cycle_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_all[i] == '0 && !clr) |=> cnt_all[i] == CNT_W'($past(cnt_all[i]) + CNT_W'(1)));

    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(code_all[i]) >= NUM_EVT && !clr) |=> $stable(cnt_all[i]));

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr |=> cnt_all[i] <= CNT_W'(1));
  end
endmodule

bind cache_perf_counters cache_perf_counters_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .rd_idx_i   (rd_idx_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .cnt_all    (cnt_all),
  .code_all   (code_all),
  .cor_all    (cor_all)
);

// File: tb/cache_perf_counters_tb.sv
`timescale 1ns/1ps
module cache_perf_counters_tb;
  localparam int NE = 54;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          we = 1'b0, wcor = 1'b0, re = 1'b0;
  logic [1:0]    widx = '0, ridx = '0;
  logic [5:0]    wcode = '0;
  logic          v64, v8;
  logic [63:0]   d64;
  logic [7:0]    d8;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";

  cache_perf_counters u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(we), .cfg_idx_i(widx),
    .cfg_evt_i(wcode), .cfg_cor_i(wcor), .rd_en_i(re), .rd_idx_i(ridx),
    .rd_valid_o(v64), .rd_data_o(d64)
  );

  cache_perf_counters #(.CNT_W(8)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(we), .cfg_idx_i(widx),
    .cfg_evt_i(wcode), .cfg_cor_i(wcor), .rd_en_i(re), .rd_idx_i(ridx),
    .rd_valid_o(v8), .rd_data_o(d8)
  );

  // behavioural reference model
  int              m_code[4] = '{NE, NE, NE, NE};
  bit              m_cor[4]  = '{0, 0, 0, 0};
  longint unsigned m64[4]    = '{0, 0, 0, 0};
  int unsigned     m8[4]     = '{0, 0, 0, 0};
  bit              e_valid = 0;
  longint unsigned e64 = 0;
  int unsigned     e8 = 0;

  always @(posedge clk) begin : mdl
    bit h[4];
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_code[i] = NE; m_cor[i] = 0; m64[i] = 0; m8[i] = 0;
      end
      e_valid = 0; e64 = 0; e8 = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        h[i] = (m_code[i] == 0) || (m_code[i] < NE && evt[m_code[i]]);
      e_valid = re;
      if (re) begin e64 = m64[ridx]; e8 = m8[ridx]; end
      for (int i = 0; i < 4; i++) begin
        if (re && int'(ridx) == i && m_cor[i]) begin
          m64[i] = h[i] ? 1 : 0;
          m8[i]  = h[i] ? 1 : 0;
        end else if (h[i]) begin
          m64[i] = m64[i] + 1;
          m8[i]  = (m8[i] + 1) % 256;
        end
      end
      if (we) begin m_code[widx] = int'(wcode); m_cor[widx] = wcor; end
    end
  end

  task automatic chk(bit ok, string what, longint unsigned act, longint unsigned exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(v64 == e_valid, "valid", 64'(v64), 64'(e_valid));
      chk(v8 == e_valid, "narrow valid", 64'(v8), 64'(e_valid));
      if (e_valid) begin
        chk(d64 == e64, "rd_data", d64, e64);
        chk(d8 == 8'(e8), "narrow rd_data", 64'(d8), 64'(e8));
      end
    end
  end

  task automatic wr(int idx, int code, bit cor);
    @(negedge clk);
    we = 1'b1; widx = 2'(idx); wcode = 6'(code); wcor = cor;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int idx);
    @(negedge clk);
    re = 1'b1; ridx = 2'(idx);
    @(negedge clk);
    re = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(v64 == 1'b0, "reset valid", 64'(v64), 0);
    chk(d64 == '0, "reset data", d64, 0);
    chk(d8 == '0, "reset narrow data", 64'(d8), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd(i);       // idle selectors: all zero

    cur_req = "R3"; wr(0, 0, 0);
    cur_req = "R4"; wr(1, 3, 0); wr(2, 6, 0);
    cur_req = "R5"; wr(3, 60, 0);
    cur_req = "R4";
    for (int c = 0; c < 40; c++) begin       // random traffic, R10 rotation
      @(negedge clk);
      evt = NE'({$urandom, $urandom});
      re = 1'b1; ridx = 2'(c % 4);
    end
    @(negedge clk); re = 1'b0; evt = '0;

    cur_req = "R8"; wr(1, 3, 1); rd(1);      // count kept after rewrite
    cur_req = "R6";
    @(negedge clk); evt[3] = 1'b1; re = 1'b1; ridx = 2'd1;
    @(negedge clk); evt[3] = 1'b0; re = 1'b0;
    rd(1); rd(1);                            // expect 1 then 0
    cur_req = "R7";
    @(negedge clk); evt = '1;
    rd(2);
    @(negedge clk); evt = '0;
    rd(2); rd(2);
    cur_req = "R8"; wr(2, 4, 0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); evt = NE'({$urandom, $urandom});
    end
    @(negedge clk); evt = '0;
    rd(2);
    cur_req = "R4"; wr(3, 0, 0);
    @(negedge clk); evt = '1;
    @(negedge clk); evt[0] = 1'b1; evt[NE-1:1] = '0; wr(1, 5, 0);
    rd(1); rd(3);
    cur_req = "R9";
    rd(0);
    repeat (300) @(negedge clk);
    rd(0); rd(3);
    cur_req = "R10"; rd(1); rd(2);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule